// File: doc/BRIEF.md
# General-Purpose I/O Port Controller

This block manages one port of sixteen general-purpose pins behind a small register bus. The bus has an address, write data, a write strobe and a read strobe, and returns read data one cycle after a read strobe. Software uses it to give each pin a function: plain input, output driven from an output latch, one of sixteen peripheral sources, or analog. Each pin's pull resistor, driver type and slew grade are exported to the pad as configuration signals.

The output latch can be loaded as a whole word. It can also be changed atomically through a write-only set/clear register, so that one write touches only the pins it names. Pin levels are brought in through a two-flop synchronizer into an input data register. Each pin has a 4-bit selector that picks which of sixteen peripheral output/enable pairs drives the pad when the pin is in peripheral mode.

Top module: `pio_port`

## Requirements
- R1: After reset every stored register is 0. Every pin is therefore an input (pin_oe all 0, pin_out all 0), no pull or open-drain is exported, and reads of offsets 0x00, 0x14, 0x20 and 0x24 return 0.
- R2: Registers are written and read back at these byte offsets: pin mode 0x00 (2 bits per pin, pin p at bits 2p+1:2p), driver type 0x04 (bit p; bits 31:16 read 0), slew grade 0x08 (2 bits per pin), pull code 0x0C (2 bits per pin), output latch 0x14 (bits 15:0), selector low 0x20 and selector high 0x24. Slew grade and driver type appear unchanged on pad_speed and pad_open_drain. Read data appears on bus_rdata the cycle after bus_re.
- R3: A write to 0x18 changes only the output latch: a 1 in bit n (n<16) sets latch bit n, a 1 in bit n+16 clears latch bit n, and a 0 leaves the bit alone. When both bits of a pin are 1, the bit ends up set.
- R4: Reads of 0x18, of 0x1C and of any unmapped offset (including 0x28 and above, and unaligned offsets) return 0. Writes to 0x1C, to unmapped offsets and to the read-only input register at 0x10 change no state.
- R5: Offset 0x10 returns pin_in as sampled through two synchronizer flops and the input register. A pin level that is stable for three clock edges is returned by a read strobed after those edges.
- R6: A pin in mode 01 with driver type 0 drives pin_out equal to its output latch bit, with pin_oe = 1.
- R7: With driver type 1 (open-drain), a drive value of 0 gives pin_oe = 1 and pin_out = 0. A drive value of 1 gives pin_oe = 0. pin_out is never 1 on an open-drain pin.
- R8: In mode 10, pin p takes periph_out and periph_oe at index 16p+s, where s is its 4-bit selector. For pins 0 to 7, s sits at bits 4p+3:4p of 0x20. For pins 8 to 15 it sits at bits 4(p-8)+3:4(p-8) of 0x24.
- R9: In mode 11 (analog) the pin is not driven, pad_analog is 1, both pulls are off, and its input bit reads 0. In mode 00 the pin is not driven.
- R10: Pull code 01 asserts pad_pull_up and code 10 asserts pad_pull_dn. Codes 00 and 11 assert neither. The two pulls are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and port clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| pin_in | input | 16 | Pad input levels (asynchronous) |
| pin_out | output | 16 | Pad output values |
| pin_oe | output | 16 | Pad output enables |
| pad_open_drain | output | 16 | Driver type per pin, 1 = open-drain |
| pad_speed | output | 32 | Slew grade, 2 bits per pin |
| pad_pull_up | output | 16 | Pull-up enable per pin |
| pad_pull_dn | output | 16 | Pull-down enable per pin |
| pad_analog | output | 16 | Analog mode indicator per pin |
| periph_out | input | 256 | Peripheral output values, index 16*pin+source |
| periph_oe | input | 256 | Peripheral output enables, index 16*pin+source |

## Verification
The hardest cases to reach from the ports are the ones where a pin's mode hides part of its state. An analog pin must read 0 even while its pad is held high and its pull code asks for a pull-up. The same pin must read 1 again once it returns to input mode. The bench holds pin_in high through both mode changes and waits for the synchronizer depth before each read. It also drives a peripheral pair through an open-drain pin, so the enable path and the value path are each exercised on their own.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int unsigned OFF_MODE  = 'h00;
  localparam int unsigned OFF_TYPE  = 'h04;
  localparam int unsigned OFF_SLEW  = 'h08;
  localparam int unsigned OFF_PULL  = 'h0C;
  localparam int unsigned OFF_IN    = 'h10;
  localparam int unsigned OFF_OUT   = 'h14;
  localparam int unsigned OFF_SETCL = 'h18;
  localparam int unsigned OFF_LOCK  = 'h1C;
  localparam int unsigned OFF_SELLO = 'h20;
  localparam int unsigned OFF_SELHI = 'h24;

  typedef enum logic [1:0] {
    PM_INPUT  = 2'b00,
    PM_OUTPUT = 2'b01,
    PM_PERIPH = 2'b10,
    PM_ANALOG = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    PULL_NONE = 2'b00,
    PULL_UP   = 2'b01,
    PULL_DOWN = 2'b10,
    PULL_RSVD = 2'b11
  } pull_code_e;

endpackage

// File: rtl/pio_regs.sv
module pio_regs #(
  parameter int unsigned NPINS  = 16,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   we,
  input  logic                   re,
  output logic [DATA_W-1:0]      rdata,
  input  logic [NPINS-1:0]       in_data,
  output logic [2*NPINS-1:0]     mode_q,
  output logic [NPINS-1:0]       otype_q,
  output logic [2*NPINS-1:0]     slew_q,
  output logic [2*NPINS-1:0]     pull_q,
  output logic [NPINS-1:0]       out_q,
  output logic [SEL_W*NPINS-1:0] sel_q
);
  import pio_pkg::*;

  localparam int unsigned SEL_ALL  = SEL_W * NPINS;
  localparam int unsigned SEL_HALF = SEL_ALL / 2;

  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFF_MODE);
  localparam logic [ADDR_W-1:0] A_TYPE  = ADDR_W'(OFF_TYPE);
  localparam logic [ADDR_W-1:0] A_SLEW  = ADDR_W'(OFF_SLEW);
  localparam logic [ADDR_W-1:0] A_PULL  = ADDR_W'(OFF_PULL);
  localparam logic [ADDR_W-1:0] A_IN    = ADDR_W'(OFF_IN);
  localparam logic [ADDR_W-1:0] A_OUT   = ADDR_W'(OFF_OUT);
  localparam logic [ADDR_W-1:0] A_SETCL = ADDR_W'(OFF_SETCL);
  localparam logic [ADDR_W-1:0] A_LOCK  = ADDR_W'(OFF_LOCK);
  localparam logic [ADDR_W-1:0] A_SELLO = ADDR_W'(OFF_SELLO);
  localparam logic [ADDR_W-1:0] A_SELHI = ADDR_W'(OFF_SELHI);

  logic [2*NPINS-1:0]   mode_d, slew_d, pull_d;
  logic [NPINS-1:0]     otype_d, out_d;
  logic [SEL_ALL-1:0]   sel_d;
  logic [DATA_W-1:0]    rd_d;
  logic [NPINS-1:0]     set_mask, clr_mask;

  assign set_mask = wdata[NPINS-1:0];
  assign clr_mask = wdata[2*NPINS-1:NPINS];

  // next-state for stored registers
  always_comb begin
    mode_d  = mode_q;
    otype_d = otype_q;
    slew_d  = slew_q;
    pull_d  = pull_q;
    out_d   = out_q;
    sel_d   = sel_q;
    if (we) begin
      unique case (addr)
        A_MODE:  mode_d  = wdata[2*NPINS-1:0];
        A_TYPE:  otype_d = wdata[NPINS-1:0];
        A_SLEW:  slew_d  = wdata[2*NPINS-1:0];
        A_PULL:  pull_d  = wdata[2*NPINS-1:0];
        A_OUT:   out_d   = wdata[NPINS-1:0];
        A_SETCL: out_d   = (out_q & ~clr_mask) | set_mask;
        A_SELLO: sel_d[SEL_HALF-1:0]       = wdata[SEL_HALF-1:0];
        A_SELHI: sel_d[SEL_ALL-1:SEL_HALF] = wdata[SEL_HALF-1:0];
        default: ;
      endcase
    end
  end

  // read mux
  always_comb begin
    rd_d = '0;
    unique case (addr)
      A_MODE:  rd_d = DATA_W'(mode_q);
      A_TYPE:  rd_d = DATA_W'(otype_q);
      A_SLEW:  rd_d = DATA_W'(slew_q);
      A_PULL:  rd_d = DATA_W'(pull_q);
      A_IN:    rd_d = DATA_W'(in_data);
      A_OUT:   rd_d = DATA_W'(out_q);
      A_SELLO: rd_d = DATA_W'(sel_q[SEL_HALF-1:0]);
      A_SELHI: rd_d = DATA_W'(sel_q[SEL_ALL-1:SEL_HALF]);
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      otype_q <= '0;
      slew_q  <= '0;
      pull_q  <= '0;
      out_q   <= '0;
      sel_q   <= '0;
    end else if (we) begin
      mode_q  <= mode_d;
      otype_q <= otype_d;
      slew_q  <= slew_d;
      pull_q  <= pull_d;
      out_q   <= out_d;
      sel_q   <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= rd_d;
    end
  end

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(we && addr == A_SETCL) |->
      ((out_q & $past(wdata[NPINS-1:0])) == $past(wdata[NPINS-1:0])));

  // R3
  clear_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(we && addr == A_SETCL) |->
      ((out_q & $past(wdata[2*NPINS-1:NPINS] & ~wdata[NPINS-1:0])) == '0));

  // R3
  setcl_keeps_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(we && addr == A_SETCL) |->
      (((out_q ^ $past(out_q)) & ~$past(wdata[2*NPINS-1:NPINS] | wdata[NPINS-1:0])) == '0));

  // R4
  wo_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(re && (addr == A_SETCL || addr == A_LOCK)) |-> (rdata == '0));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we && addr == A_MODE) |-> $stable(mode_q));

endmodule

// File: rtl/pio_insync.sv
module pio_insync #(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] analog_mask,
  output logic [NPINS-1:0] in_q
);
  logic [NPINS-1:0] meta_q, stab_q, in_d;

  always_comb begin
    in_d = stab_q & ~analog_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
      in_q   <= '0;
    end else begin
      meta_q <= pin_in;
      stab_q <= meta_q;
      in_q   <= in_d;
    end
  end

endmodule

// File: rtl/pio_pin_path.sv
module pio_pin_path #(
  parameter int unsigned NALT  = 16,
  parameter int unsigned SEL_W = $clog2(NALT)
) (
  input  logic [1:0]       mode,
  input  logic             otype,
  input  logic             out_bit,
  input  logic [1:0]       pull,
  input  logic [SEL_W-1:0] sel,
  input  logic [NALT-1:0]  alt_val,
  input  logic [NALT-1:0]  alt_en,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             pull_up,
  output logic             pull_dn,
  output logic             analog
);
  import pio_pkg::*;

  logic drv_val, drv_en;

  always_comb begin
    drv_val = 1'b0;
    drv_en  = 1'b0;
    unique case (mode)
      PM_OUTPUT: begin
        drv_val = out_bit;
        drv_en  = 1'b1;
      end
      PM_PERIPH: begin
        drv_val = alt_val[sel];
        drv_en  = alt_en[sel];
      end
      default: ;
    endcase
  end

  always_comb begin
    if (otype) begin
      pin_out = 1'b0;
      pin_oe  = drv_en & ~drv_val;
    end else begin
      pin_out = drv_en & drv_val;
      pin_oe  = drv_en;
    end
  end

  always_comb begin
    analog  = (mode == PM_ANALOG);
    pull_up = !analog && (pull == PULL_UP);
    pull_dn = !analog && (pull == PULL_DOWN);
  end

endmodule

// File: rtl/pio_port.sv
module pio_port #(
  parameter int unsigned NPINS  = 16,
  parameter int unsigned NALT   = 16,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  input  logic                    bus_we,
  input  logic                    bus_re,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [NPINS-1:0]        pin_in,
  output logic [NPINS-1:0]        pin_out,
  output logic [NPINS-1:0]        pin_oe,
  output logic [NPINS-1:0]        pad_open_drain,
  output logic [2*NPINS-1:0]      pad_speed,
  output logic [NPINS-1:0]        pad_pull_up,
  output logic [NPINS-1:0]        pad_pull_dn,
  output logic [NPINS-1:0]        pad_analog,
  input  logic [NPINS*NALT-1:0]   periph_out,
  input  logic [NPINS*NALT-1:0]   periph_oe
);
  localparam int unsigned SEL_W = $clog2(NALT);

  logic                    rst_q1, rst_sync;
  logic [2*NPINS-1:0]      mode_q, pull_q;
  logic [NPINS-1:0]        otype_q, out_q, in_q;
  logic [SEL_W*NPINS-1:0]  sel_q;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1   <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_q1   <= 1'b1;
      rst_sync <= rst_q1;
    end
  end

  pio_regs #(
    .NPINS (NPINS),
    .SEL_W (SEL_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .we     (bus_we),
    .re     (bus_re),
    .rdata  (bus_rdata),
    .in_data(in_q),
    .mode_q (mode_q),
    .otype_q(otype_q),
    .slew_q (pad_speed),
    .pull_q (pull_q),
    .out_q  (out_q),
    .sel_q  (sel_q)
  );

  pio_insync #(.NPINS(NPINS)) u_insync (
    .clk        (clk),
    .rst_n      (rst_sync),
    .pin_in     (pin_in),
    .analog_mask(pad_analog),
    .in_q       (in_q)
  );

  assign pad_open_drain = otype_q;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pio_pin_path #(.NALT(NALT), .SEL_W(SEL_W)) u_pin (
      .mode   (mode_q[2*p +: 2]),
      .otype  (otype_q[p]),
      .out_bit(out_q[p]),
      .pull   (pull_q[2*p +: 2]),
      .sel    (sel_q[SEL_W*p +: SEL_W]),
      .alt_val(periph_out[NALT*p +: NALT]),
      .alt_en (periph_oe[NALT*p +: NALT]),
      .pin_out(pin_out[p]),
      .pin_oe (pin_oe[p]),
      .pull_up(pad_pull_up[p]),
      .pull_dn(pad_pull_dn[p]),
      .analog (pad_analog[p])
    );
  end

  // R7
  od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    ((pin_out & pad_open_drain) == '0));

  // R9
  analog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (((pin_oe | pad_pull_up | pad_pull_dn) & pad_analog) == '0));

  // R10
  pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    ((pad_pull_up & pad_pull_dn) == '0));

  // R9
  analog_input_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    $past(pad_analog == '1) && (pad_analog == '1) |=> (in_q == '0));

endmodule

// File: tb/pio_port_bench.sv
module pio_port_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [5:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic         bus_we = 1'b0;
  logic         bus_re = 1'b0;
  logic [31:0]  bus_rdata;
  logic [15:0]  pin_in = '0;
  logic [15:0]  pin_out, pin_oe, pad_open_drain, pad_pull_up, pad_pull_dn, pad_analog;
  logic [31:0]  pad_speed;
  logic [255:0] periph_out = '0;
  logic [255:0] periph_oe = '0;

  int total = 0;
  int fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  pio_port u_pio_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pad_open_drain(pad_open_drain),
    .pad_speed(pad_speed), .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn),
    .pad_analog(pad_analog), .periph_out(periph_out), .periph_oe(periph_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  // driver: queue the expected value, then strobe the read
  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  // monitor: data appears the cycle after the strobe
  initial begin
    forever begin
      @(posedge clk);
      if (bus_re) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check("read with empty scoreboard", 32'd1, 32'd0);
        end else begin
          check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 pin_oe", 32'(pin_oe), 32'h0);
    check("R1 pin_out", 32'(pin_out), 32'h0);
    check("R1 pulls", 32'(pad_pull_up | pad_pull_dn | pad_open_drain), 32'h0);
    rd(6'h00, 32'h0, "R1 mode reset");
    rd(6'h14, 32'h0, "R1 latch reset");
    rd(6'h20, 32'h0, "R1 sel low reset");
    rd(6'h24, 32'h0, "R1 sel high reset");

    // R2 map and export
    wr(6'h08, 32'hA5A5_1234);
    rd(6'h08, 32'hA5A5_1234, "R2 slew readback");
    check("R2 pad_speed", pad_speed, 32'hA5A5_1234);
    wr(6'h04, 32'hFFFF_00F0);
    rd(6'h04, 32'h0000_00F0, "R2 type readback");
    check("R2 pad_open_drain", 32'(pad_open_drain), 32'h0000_00F0);
    wr(6'h04, 32'h0);
    wr(6'h20, 32'h1234_5678);
    wr(6'h24, 32'h9ABC_DEF0);
    rd(6'h20, 32'h1234_5678, "R2 sel low readback");
    rd(6'h24, 32'h9ABC_DEF0, "R2 sel high readback");
    wr(6'h0C, 32'h0F0F_0F0F);
    rd(6'h0C, 32'h0F0F_0F0F, "R2 pull readback");
    wr(6'h0C, 32'h0);

    // R3 set/clear
    wr(6'h14, 32'h0000_00FF);
    rd(6'h14, 32'h0000_00FF, "R2 latch readback");
    wr(6'h18, 32'h0001_0100);
    rd(6'h14, 32'h0000_01FE, "R3 set bit8 clear bit0");
    wr(6'h18, 32'h0200_0200);
    rd(6'h14, 32'h0000_03FE, "R3 set wins on bit9");
    wr(6'h18, 32'h0);
    rd(6'h14, 32'h0000_03FE, "R3 zero write no effect");

    // R4 write-only, lock and unmapped
    rd(6'h18, 32'h0, "R4 setclr reads 0");
    wr(6'h1C, 32'hFFFF_FFFF);
    rd(6'h1C, 32'h0, "R4 lock reads 0");
    wr(6'h28, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    wr(6'h15, 32'hFFFF_FFFF);
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h28, 32'h0, "R4 unmapped reads 0");
    rd(6'h15, 32'h0, "R4 unaligned reads 0");
    rd(6'h14, 32'h0000_03FE, "R4 latch untouched");
    rd(6'h00, 32'h0, "R4 mode untouched");
    rd(6'h10, 32'h0, "R4 input untouched");
    rd(6'h20, 32'h1234_5678, "R4 sel untouched");

    // R6 push-pull output
    wr(6'h00, 32'h5555_5555);
    check("R6 oe all", 32'(pin_oe), 32'h0000_FFFF);
    check("R6 out follows latch", 32'(pin_out), 32'h0000_03FE);

    // R7 open-drain
    wr(6'h04, 32'h0000_000F);
    check("R7 od oe", 32'(pin_oe), 32'h0000_FFF1);
    check("R7 od out", 32'(pin_out), 32'h0000_03F0);
    wr(6'h04, 32'h0);

    // R8 peripheral mux: pin3 source 5, pin12 source 10
    periph_out[3*16+5] = 1'b1; periph_oe[3*16+5] = 1'b1;
    periph_out[12*16+10] = 1'b0; periph_oe[12*16+10] = 1'b1;
    periph_out[12*16+9] = 1'b1; periph_oe[12*16+9] = 1'b1;
    wr(6'h20, 32'h0000_5000);
    wr(6'h24, 32'h000A_0000);
    wr(6'h00, 32'h0200_0080);
    check("R8 periph oe", 32'(pin_oe), 32'h0000_1008);
    check("R8 periph out", 32'(pin_out), 32'h0000_0008);
    wr(6'h24, 32'h0009_0000);
    check("R8 high sel change", 32'(pin_out), 32'h0000_1008);
    wr(6'h04, 32'h0000_0008);
    check("R7 periph od releases", 32'(pin_oe), 32'h0000_1000);
    wr(6'h04, 32'h0);

    // R9 analog hides input and pulls
    pin_in = 16'hFFFF;
    wr(6'h0C, 32'h5555_5555);
    wr(6'h00, 32'hFFFF_FFFF);
    repeat (3) @(posedge clk);
    rd(6'h10, 32'h0, "R9 analog input reads 0");
    check("R9 analog no pull", 32'(pad_pull_up | pad_pull_dn), 32'h0);
    check("R9 analog no drive", 32'(pin_oe), 32'h0);
    check("R9 analog flag", 32'(pad_analog), 32'h0000_FFFF);
    wr(6'h00, 32'h0);
    repeat (3) @(posedge clk);
    rd(6'h10, 32'h0000_FFFF, "R5 input after analog");
    check("R10 pull up restored", 32'(pad_pull_up), 32'h0000_FFFF);
    check("R9 input mode no drive", 32'(pin_oe), 32'h0);

    // R10 pull codes
    wr(6'h0C, 32'h0000_0039);
    check("R10 pull up", 32'(pad_pull_up), 32'h0000_0001);
    check("R10 pull down", 32'(pad_pull_dn), 32'h0000_0002);

    // R5 input sampling
    @(negedge clk);
    pin_in = 16'hA5C3;
    repeat (3) @(posedge clk);
    rd(6'h10, 32'h0000_A5C3, "R5 input pattern");
    pin_in = 16'h5A3C;
    repeat (3) @(posedge clk);
    rd(6'h10, 32'h0000_5A3C, "R5 second pattern");

    repeat (4) @(negedge clk);
    check("scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule